// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the storage stage that sits behind one programmable sum-of-products cell. It receives the combinational sum term, a second data term, and dedicated product terms for clock, clock enable, preset and clear. It delivers either a registered bit or, when bypassed, the raw sum term. Static configuration inputs choose how the single state bit behaves (data, toggle, set/reset with toggle, or set/reset with hold), which clock source advances it, and whether the dedicated active-low global clear may reset it.

The block runs on one fabric clock. The global clock pins and the product-term clock are treated as sampled signals. A rising edge of the selected source, seen from one fabric cycle to the next, is one "clock event" of the emulated register. Preset and clear take effect on the output in the same cycle they are asserted, with no clock event needed, and they also force the stored bit. Clear wins over preset.

Top module: `macrocell_reg`

## Requirements
- R1: In data mode (cfg_kind=0), a clock event stores sop, and the output shows the new value from the following fabric cycle. Without a clock event or a forcing input, the stored bit does not change.
- R2: In toggle mode (cfg_kind=1), a clock event inverts the stored bit when sop=1 and keeps it when sop=0.
- R3: In J/K mode (cfg_kind=2, J=sop, K=aux), a clock event holds on J=0/K=0, sets on 1/0, clears on 0/1 and inverts on 1/1.
- R4: In S/R mode (cfg_kind=3, S=sop, R=aux), a clock event holds on 0/0, sets on 1/0 and clears on 0/1. When S=R=1 the bit holds and illegal_sr is high in that same cycle, unless bypass is on.
- R5: With cfg_bypass=1, mc_out equals sop in the same cycle, whatever the preset, clear and clock inputs are doing.
- R6: Clock modes 0 and 3 take gclk[cfg_gsel], inverted when cfg_ginv=1. A clock event is a 0-to-1 change of that value between consecutive fabric cycles.
- R7: In clock mode 1, the same global source is used, but an event is dropped while pt_ena is low.
- R8: In clock mode 2, a 0-to-1 change of pt_clk is the clock event, and the global clocks are ignored.
- R9: pt_pre high (with no clear) drives mc_out to 1 in the same cycle and leaves 1 stored.
- R10: pt_clr high drives mc_out to 0 in the same cycle and leaves 0 stored, even when pt_pre is also high.
- R11: gclr_n low acts as a clear when cfg_gclr_en=1. With cfg_gclr_en=0 it has no effect.
- R12: While rst_n is low, the stored bit is 0. A clock source that is already high when reset is released is not taken as an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low fabric reset |
| gclk | input | NUM_GCLK | Global clock pins (sampled) |
| cfg_kind | input | 2 | Storage behaviour: 0 data, 1 toggle, 2 J/K, 3 S/R |
| cfg_clk_mode | input | 2 | 0 global, 1 gated global, 2 product-term clock, 3 as 0 |
| cfg_gsel | input | SEL_W | Global clock index |
| cfg_ginv | input | 1 | Take complement of selected global clock |
| cfg_bypass | input | 1 | Route sop straight to the output |
| cfg_gclr_en | input | 1 | Allow the global clear to reset this bit |
| sop | input | 1 | Sum term: D, T, J or S |
| aux | input | 1 | Second term: K or R |
| pt_clk | input | 1 | Product-term clock |
| pt_ena | input | 1 | Active-high clock enable for mode 1 |
| pt_pre | input | 1 | Active-high asynchronous preset term |
| pt_clr | input | 1 | Active-high asynchronous clear term |
| gclr_n | input | 1 | Active-low global clear |
| mc_out | output | 1 | Registered or bypassed result |
| illegal_sr | output | 1 | S and R both high in S/R mode |

## Verification
The hold assertions assume that every clock source stays at each level for at least one fabric cycle. This way a rising edge is always visible as a 0 sample followed by a 1 sample. The stimulus changes every input only just after a falling fabric edge, so each level lasts at least a full cycle. Configuration changes are allowed between cycles, because a selection change that exposes a 0-to-1 step is by definition an event, and the bench model counts it the same way. Random phases keep preset and clear rare, so that the stored bit spends most cycles responding to clock events.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    typedef enum logic [1:0] {
        FF_D  = 2'd0,
        FF_T  = 2'd1,
        FF_JK = 2'd2,
        FF_SR = 2'd3
    } ff_kind_e;

    typedef enum logic [1:0] {
        CK_GLOBAL = 2'd0,
        CK_GATED  = 2'd1,
        CK_TERM   = 2'd2,
        CK_SPARE  = 2'd3
    } ck_mode_e;

    // history of the selected clock source
    typedef struct packed {
        logic src;
    } pick_state_t;

    // the emulated storage bit
    typedef struct packed {
        logic bit_v;
    } cell_state_t;

endpackage

// File: rtl/mcr_clk_pick.sv
module mcr_clk_pick
    import mcr_pkg::*;
#(
    parameter int NUM_GCLK = 2,
    parameter int SEL_W    = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic [SEL_W-1:0]    gsel,
    input  logic                ginv,
    input  ck_mode_e            mode,
    input  logic                pt_clk,
    input  logic                pt_ena,
    output logic                fire
);

    logic [NUM_GCLK-1:0] g_true;
    logic [NUM_GCLK-1:0] g_comp;
    logic                src_now;
    logic                rise;
    pick_state_t         st_d, st_q;

    // both polarities of every global clock
    for (genvar g = 0; g < NUM_GCLK; g++) begin : g_pol
        assign g_true[g] = gclk[g];
        assign g_comp[g] = ~gclk[g];
    end

    always_comb begin
        logic gsrc;
        gsrc = 1'b0;
        if (int'(gsel) < NUM_GCLK) begin
            gsrc = ginv ? g_comp[gsel] : g_true[gsel];
        end
        src_now  = (mode == CK_TERM) ? pt_clk : gsrc;
        rise     = src_now & ~st_q.src;
        fire     = rise & ((mode != CK_GATED) | pt_ena);
        st_d.src = src_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.src <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // a rising edge needs a low sample first, so events never come back to back
    AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R6

endmodule

// File: rtl/mcr_ff_next.sv
module mcr_ff_next
    import mcr_pkg::*;
(
    input  ff_kind_e kind,
    input  logic     q_cur,
    input  logic     in_a,
    input  logic     in_b,
    output logic     q_nxt,
    output logic     sr_conflict
);

    always_comb begin
        q_nxt       = q_cur;
        sr_conflict = 1'b0;
        unique case (kind)
            FF_D:  q_nxt = in_a;
            FF_T:  q_nxt = q_cur ^ in_a;
            FF_JK: begin
                unique case ({in_a, in_b})
                    2'b10:   q_nxt = 1'b1;
                    2'b01:   q_nxt = 1'b0;
                    2'b11:   q_nxt = ~q_cur;
                    default: q_nxt = q_cur;
                endcase
            end
            FF_SR: begin
                unique case ({in_a, in_b})
                    2'b10:   q_nxt = 1'b1;
                    2'b01:   q_nxt = 1'b0;
                    2'b11: begin
                        q_nxt       = q_cur;
                        sr_conflict = 1'b1;
                    end
                    default: q_nxt = q_cur;
                endcase
            end
            default: q_nxt = q_cur;
        endcase
    end

endmodule

// File: rtl/macrocell_reg.sv
module macrocell_reg
    import mcr_pkg::*;
#(
    parameter int NUM_GCLK = 2,
    localparam int SEL_W   = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic [1:0]          cfg_kind,
    input  logic [1:0]          cfg_clk_mode,
    input  logic [SEL_W-1:0]    cfg_gsel,
    input  logic                cfg_ginv,
    input  logic                cfg_bypass,
    input  logic                cfg_gclr_en,
    input  logic                sop,
    input  logic                aux,
    input  logic                pt_clk,
    input  logic                pt_ena,
    input  logic                pt_pre,
    input  logic                pt_clr,
    input  logic                gclr_n,
    output logic                mc_out,
    output logic                illegal_sr
);

    ff_kind_e    kind;
    ck_mode_e    mode;
    logic        fire;
    logic        q_nxt;
    logic        sr_conflict;
    logic        clr_any;
    logic        force_any;
    cell_state_t st_d, st_q;

    assign kind = ff_kind_e'(cfg_kind);
    assign mode = ck_mode_e'(cfg_clk_mode);

    mcr_clk_pick #(
        .NUM_GCLK (NUM_GCLK),
        .SEL_W    (SEL_W)
    ) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .gclk   (gclk),
        .gsel   (cfg_gsel),
        .ginv   (cfg_ginv),
        .mode   (mode),
        .pt_clk (pt_clk),
        .pt_ena (pt_ena),
        .fire   (fire)
    );

    mcr_ff_next u_next (
        .kind        (kind),
        .q_cur       (st_q.bit_v),
        .in_a        (sop),
        .in_b        (aux),
        .q_nxt       (q_nxt),
        .sr_conflict (sr_conflict)
    );

    always_comb begin
        clr_any   = pt_clr | (cfg_gclr_en & ~gclr_n);
        force_any = clr_any | pt_pre;
        st_d      = st_q;
        if (clr_any) begin
            st_d.bit_v = 1'b0;
        end else if (pt_pre) begin
            st_d.bit_v = 1'b1;
        end else if (fire) begin
            st_d.bit_v = q_nxt;
        end
        if (cfg_bypass) begin
            mc_out = sop;
        end else if (clr_any) begin
            mc_out = 1'b0;
        end else if (pt_pre) begin
            mc_out = 1'b1;
        end else begin
            mc_out = st_q.bit_v;
        end
        illegal_sr = sr_conflict & ~cfg_bypass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bit_v <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !force_any) |=> $stable(st_q.bit_v)); // R1

    AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_sr && !force_any) |=> $stable(st_q.bit_v)); // R4

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CK_GATED && !pt_ena && !force_any) |=> $stable(st_q.bit_v)); // R7

    AST_PRESET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_pre && !clr_any && !cfg_bypass) |-> mc_out); // R9

    AST_CLEAR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_clr && !cfg_bypass) |-> !mc_out); // R10

    AST_GCLR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_gclr_en && !gclr_n) |=> !st_q.bit_v); // R11

endmodule

// File: tb/macrocell_reg_test.sv
module macrocell_reg_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] gclk;
    logic [1:0] cfg_kind, cfg_clk_mode;
    logic       cfg_gsel, cfg_ginv, cfg_bypass, cfg_gclr_en;
    logic       sop, aux, pt_clk, pt_ena, pt_pre, pt_clr, gclr_n;
    logic       mc_out, illegal_sr;

    int checks = 0;
    int errors = 0;
    int mq     = 0;
    int prev   = 1;

    always #5 clk = ~clk;

    macrocell_reg uut (
        .clk(clk), .rst_n(rst_n), .gclk(gclk), .cfg_kind(cfg_kind),
        .cfg_clk_mode(cfg_clk_mode), .cfg_gsel(cfg_gsel), .cfg_ginv(cfg_ginv),
        .cfg_bypass(cfg_bypass), .cfg_gclr_en(cfg_gclr_en), .sop(sop), .aux(aux),
        .pt_clk(pt_clk), .pt_ena(pt_ena), .pt_pre(pt_pre), .pt_clr(pt_clr),
        .gclr_n(gclr_n), .mc_out(mc_out), .illegal_sr(illegal_sr)
    );

    function automatic int clr_now();
        return (pt_clr || (cfg_gclr_en && !gclr_n)) ? 1 : 0;
    endfunction

    function automatic int exp_out();
        if (cfg_bypass) return int'(sop);
        if (clr_now() != 0) return 0;
        if (pt_pre) return 1;
        return mq;
    endfunction

    function automatic int next_val();
        int s = int'(sop);
        int r = int'(aux);
        case (cfg_kind)
            2'd0: return s;
            2'd1: return (s != 0) ? 1 - mq : mq;
            default: begin
                if (s == 1 && r == 0) return 1;
                if (s == 0 && r == 1) return 0;
                if (s == 1 && r == 1 && cfg_kind == 2'd2) return 1 - mq;
                return mq;
            end
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // one fabric cycle: compare in the low phase, then advance the model at the edge
    task automatic cyc(string tag);
        int src, fire, eill;
        #2;
        check(tag, int'(mc_out), exp_out());
        eill = (cfg_kind == 2'd3 && sop && aux && !cfg_bypass) ? 1 : 0;
        check("R4", int'(illegal_sr), eill);
        @(posedge clk);
        src = (cfg_clk_mode == 2'd2) ? int'(pt_clk) : int'(gclk[cfg_gsel] ^ cfg_ginv);
        if (!rst_n) begin
            mq = 0; prev = 1;
        end else begin
            fire = (src == 1 && prev == 0 && (cfg_clk_mode != 2'd1 || pt_ena)) ? 1 : 0;
            if (clr_now() != 0) mq = 0;
            else if (pt_pre) mq = 1;
            else if (fire != 0) mq = next_val();
            prev = src;
        end
        @(negedge clk);
        #1;
    endtask

    // low then high on global clock 0 with the given data
    task automatic gpulse(string tag, logic a, logic b);
        sop = a; aux = b; gclk[0] = 1'b0; cyc(tag);
        gclk[0] = 1'b1; cyc(tag);
        cyc(tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; gclk = 2'b01; cfg_kind = 0; cfg_clk_mode = 0; cfg_gsel = 0;
        cfg_ginv = 0; cfg_bypass = 0; cfg_gclr_en = 0; sop = 1; aux = 0;
        pt_clk = 0; pt_ena = 0; pt_pre = 0; pt_clr = 0; gclr_n = 1;
        @(negedge clk); #1;
        for (int i = 0; i < 3; i++) cyc("R12");
        rst_n = 1;
        for (int i = 0; i < 3; i++) cyc("R12");   // clock already high: no event
        // R1 data mode
        gpulse("R1", 1, 0);
        gpulse("R1", 0, 0);
        gpulse("R1", 1, 0);
        // R2 toggle mode
        cfg_kind = 1;
        gpulse("R2", 1, 0); gpulse("R2", 0, 0); gpulse("R2", 1, 0);
        // R3 J/K
        cfg_kind = 2;
        gpulse("R3", 1, 0); gpulse("R3", 0, 0); gpulse("R3", 1, 1);
        gpulse("R3", 0, 1); gpulse("R3", 1, 1);
        // R4 S/R, with hold on conflict
        cfg_kind = 3;
        gpulse("R4", 1, 0); gpulse("R4", 1, 1); gpulse("R4", 0, 1); gpulse("R4", 1, 1);
        // R6 inverted clock 1 in data mode
        cfg_kind = 0; cfg_gsel = 1; cfg_ginv = 1; gclk[1] = 1'b0;
        cyc("R6");
        sop = 1; gclk[1] = 1'b1; cyc("R6");
        gclk[1] = 1'b0; cyc("R6"); cyc("R6");
        cfg_gsel = 0; cfg_ginv = 0;
        // R7 gated clock
        cfg_clk_mode = 1; pt_ena = 0;
        gpulse("R7", 0, 0);
        pt_ena = 1; gpulse("R7", 0, 0);
        // R8 product-term clock, global clock ignored
        cfg_clk_mode = 2; gclk = 2'b00;
        sop = 1; cyc("R8"); gclk = 2'b11; cyc("R8");
        pt_clk = 1; cyc("R8"); cyc("R8");
        pt_clk = 0; sop = 0; cyc("R8"); pt_clk = 1; cyc("R8"); cyc("R8");
        // R9 / R10 preset and clear
        pt_pre = 1; cyc("R9"); pt_pre = 0; cyc("R9");
        pt_pre = 1; pt_clr = 1; cyc("R10"); pt_pre = 0; pt_clr = 0; cyc("R10");
        // R11 global clear gating
        pt_pre = 1; cyc("R11"); pt_pre = 0;
        gclr_n = 0; cfg_gclr_en = 0; cyc("R11"); cyc("R11");
        cfg_gclr_en = 1; cyc("R11"); gclr_n = 1; cyc("R11");
        // R5 bypass
        cfg_bypass = 1; pt_pre = 1; sop = 0; cyc("R5");
        pt_pre = 0; pt_clr = 1; sop = 1; cyc("R5");
        pt_clr = 0; cfg_bypass = 0; cyc("R5");
        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) begin
                cfg_kind = 2'($urandom); cfg_clk_mode = 2'($urandom);
                cfg_gsel = 1'($urandom); cfg_ginv = 1'($urandom);
                cfg_bypass = ($urandom % 8) == 0; cfg_gclr_en = 1'($urandom);
            end
            gclk = 2'($urandom); pt_clk = 1'($urandom); pt_ena = 1'($urandom);
            sop = 1'($urandom); aux = 1'($urandom);
            pt_pre = ($urandom % 16) == 0; pt_clr = ($urandom % 16) == 0;
            gclr_n = ($urandom % 16) != 0;
            cyc("R1");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule